// File: doc/BRIEF.md
# Bus Transaction Scheduler with Snoop Queue

This block sits between a processor core and a shared split-transaction memory bus. Three transaction sources compete for the processor's issue slot: snoop-data replies, read requests and cache-victim writes. Each cycle the block picks one of them and places it in a single output register that drives the bus. Snoop data always goes first. Reads normally go before victim writes. The order flips to write-first when the memory controller reports that it cannot take reads and both the read buffer and the write buffer are full. Reads are also held back once six are in flight, until a read return retires one. A bus request is raised in the same cycle that any source shows intent. A request taken in one cycle appears on the bus in the next cycle, with no buffering in between.

Coherency checks arrive from the bus and are never refused. Cache snoops fall into a ten-entry queue and TLB snoops into a separate three-entry queue. The head cache snoop is first offered to the core as a light query. In the following cycle the core answers whether the line's state must change. Only in that case is a full query issued for the same address. The head leaves the queue only when its query sequence ends. The TLB queue head is presented on its own valid/ready port.

Every stream port uses valid/ready. A source holds valid, address and kind steady until the block raises ready in that cycle. The bus side may hold `tx_ready` low, and the selected transaction then stays unchanged. The snoop input has no ready: the environment may push one snoop per cycle, as long as the target queue has room.

Top module: `bus_sched_top`

## Requirements
- R1: After reset, `tx_valid`, `bus_req`, `lq_valid`, `fq_valid`, `tq_valid`, `sd_ready`, `rd_ready` and `wr_ready` are all 0.
- R2: When the output slot is free (`tx_valid`=0 or `tx_ready`=1), a valid snoop-data source is taken before a read or a write. Otherwise an eligible read is taken before a write. `tx_kind` encodes 0 none, 1 snoop data, 2 read, 3 victim write.
- R3: When `mc_busy`, `rd_full` and `wr_full` are all 1 and no snoop data is pending, a valid victim write is taken ahead of a valid read.
- R4: `bus_req` is 1 in any cycle in which a source valid is high or a transaction is held. A source taken at a clock edge appears on `tx_valid`/`tx_kind`/`tx_addr` right after that edge.
- R5: While `tx_valid`=1 and `tx_ready`=0, `tx_kind` and `tx_addr` stay unchanged and no source is taken.
- R6: At most MAX_RD (6) reads are outstanding. A read is counted when it is taken and retired by a one-cycle `rd_ret` pulse. A read is not taken while the count is at the limit, even in the cycle of a return.
- R7: Every pushed snoop is kept. Up to 10 cache snoops (`sn_is_tlb`=0) and 3 TLB snoops (`sn_is_tlb`=1) are held at once, with no loss.
- R8: Each cache snoop is offered once as a light query (`lq_valid`). A full query (`fq_valid`, same address) follows only if `lq_chg` is 1 in the cycle after the light-query handshake.
- R9: Cache snoops are queried strictly in arrival order. `lq_valid` and `lq_addr` hold steady until `lq_ready`.
- R10: TLB snoops are presented on `tq_valid`/`tq_addr` in arrival order. Each one is removed on a `tq_ready` handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sd_valid | input | 1 | Snoop-data reply pending |
| sd_ready | output | 1 | Snoop-data reply taken this cycle |
| sd_addr | input | AW | Snoop-data reply address |
| rd_valid | input | 1 | Read request pending |
| rd_ready | output | 1 | Read request taken this cycle |
| rd_addr | input | AW | Read request address |
| rd_full | input | 1 | Read buffer full |
| wr_valid | input | 1 | Victim write pending |
| wr_ready | output | 1 | Victim write taken this cycle |
| wr_addr | input | AW | Victim write address |
| wr_full | input | 1 | Write buffer full |
| mc_busy | input | 1 | Memory controller cannot accept reads |
| rd_ret | input | 1 | One outstanding read has returned |
| bus_req | output | 1 | Bus arbitration request |
| tx_valid | output | 1 | Selected transaction valid |
| tx_ready | input | 1 | Bus has taken the transaction |
| tx_kind | output | 2 | Transaction kind (0 none, 1 snoop data, 2 read, 3 write) |
| tx_addr | output | AW | Transaction address |
| sn_valid | input | 1 | Incoming coherency check |
| sn_is_tlb | input | 1 | Incoming check targets the TLB |
| sn_addr | input | AW | Incoming check address |
| lq_valid | output | 1 | Light query to core |
| lq_ready | input | 1 | Core takes the light query |
| lq_addr | output | AW | Light query address |
| lq_chg | input | 1 | Core answer: line state must change |
| fq_valid | output | 1 | Full query to core |
| fq_ready | input | 1 | Core takes the full query |
| fq_addr | output | AW | Full query address |
| tq_valid | output | 1 | TLB snoop to core |
| tq_ready | input | 1 | Core takes the TLB snoop |
| tq_addr | output | AW | TLB snoop address |

## Verification
The first overlap is a new cache snoop arriving in the same cycle the queue head retires. The bench provokes it by pushing snoops on consecutive cycles while the core accepts light queries at once. It then compares the whole logged query stream, light and full, against arrival order and the answer bit. The second overlap is a read return in the same cycle as a blocked read at the six-read limit. The bench holds a read pending at the limit, pulses the return, and expects `rd_ready` to stay low in that cycle and rise in the next.

// File: rtl/bus_sched_pkg.sv
package bus_sched_pkg;

  typedef enum logic [1:0] {
    TK_NONE    = 2'd0,
    TK_SNPDATA = 2'd1,
    TK_READ    = 2'd2,
    TK_VICTIM  = 2'd3
  } txk_e;

  typedef enum logic [1:0] {
    FW_IDLE = 2'd0,
    FW_LQ   = 2'd1,
    FW_WAIT = 2'd2,
    FW_FQ   = 2'd3
  } fw_state_e;

endpackage

// File: rtl/bus_sched_fifo.sv
module bus_sched_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic [W-1:0]                 din,
  input  logic                         pop,
  output logic                         head_valid,
  output logic [W-1:0]                 head,
  output logic [$clog2(DEPTH+1)-1:0]   count
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH-1);
  localparam logic [CW-1:0] FULLC = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  assign do_push = push && (cnt != FULLC);
  assign do_pop  = pop && (cnt != '0);

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= step(wp);
      if (do_pop)  rp <= step(rp);
      if (do_push && !do_pop)      cnt <= cnt + 1'b1;
      else if (do_pop && !do_push) cnt <= cnt - 1'b1;
    end
  end

  assign head_valid = (cnt != '0);
  assign head       = mem[rp];
  assign count      = cnt;

endmodule

// File: rtl/bus_sched_rdcred.sv
module bus_sched_rdcred #(
  parameter int MAX = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       issue,
  input  logic                       retire,
  output logic                       allow,
  output logic [$clog2(MAX+1)-1:0]   count
);

  localparam int CW = $clog2(MAX+1);
  localparam logic [CW-1:0] LIMIT = CW'(MAX);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (issue && !retire) begin
      cnt <= cnt + 1'b1;
    end else if (retire && !issue && cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign allow = (cnt < LIMIT);
  assign count = cnt;

endmodule

// File: rtl/bus_sched_arb.sv
module bus_sched_arb
  import bus_sched_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sd_valid,
  input  logic [AW-1:0] sd_addr,
  input  logic          rd_valid,
  input  logic [AW-1:0] rd_addr,
  input  logic          rd_allow,
  input  logic          wr_valid,
  input  logic [AW-1:0] wr_addr,
  input  logic          rd_full,
  input  logic          wr_full,
  input  logic          mc_busy,
  input  logic          tx_ready,
  output logic          sd_ready,
  output logic          rd_ready,
  output logic          wr_ready,
  output logic          tx_valid,
  output txk_e          tx_kind,
  output logic [AW-1:0] tx_addr,
  output logic          bus_req
);

  logic          slot_free;
  logic          rd_ok;
  logic          write_first;
  txk_e          pick;
  logic [AW-1:0] pick_addr;
  logic          vq;
  txk_e          kq;
  logic [AW-1:0] aq;

  assign slot_free   = !vq || tx_ready;
  assign rd_ok       = rd_valid && rd_allow;
  assign write_first = mc_busy && rd_full && wr_full;

  always_comb begin
    pick      = TK_NONE;
    pick_addr = '0;
    if (sd_valid) begin
      pick      = TK_SNPDATA;
      pick_addr = sd_addr;
    end else if (write_first && wr_valid) begin
      pick      = TK_VICTIM;
      pick_addr = wr_addr;
    end else if (rd_ok) begin
      pick      = TK_READ;
      pick_addr = rd_addr;
    end else if (wr_valid) begin
      pick      = TK_VICTIM;
      pick_addr = wr_addr;
    end
  end

  assign sd_ready = slot_free && (pick == TK_SNPDATA);
  assign rd_ready = slot_free && (pick == TK_READ);
  assign wr_ready = slot_free && (pick == TK_VICTIM);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vq <= 1'b0;
      kq <= TK_NONE;
      aq <= '0;
    end else if (slot_free) begin
      vq <= (pick != TK_NONE);
      kq <= pick;
      aq <= pick_addr;
    end
  end

  assign tx_valid = vq;
  assign tx_kind  = vq ? kq : TK_NONE;
  assign tx_addr  = aq;
  assign bus_req  = sd_valid || rd_valid || wr_valid || vq;

endmodule

// File: rtl/bus_sched_fwd.sv
module bus_sched_fwd
  import bus_sched_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          head_valid,
  input  logic [AW-1:0] head_addr,
  output logic          pop,
  output logic          lq_valid,
  input  logic          lq_ready,
  output logic [AW-1:0] lq_addr,
  input  logic          lq_chg,
  output logic          fq_valid,
  input  logic          fq_ready,
  output logic [AW-1:0] fq_addr
);

  fw_state_e st, st_n;

  always_comb begin
    st_n = st;
    pop  = 1'b0;
    unique case (st)
      FW_IDLE: if (head_valid) st_n = FW_LQ;
      FW_LQ:   if (lq_ready)   st_n = FW_WAIT;
      FW_WAIT: begin
        if (lq_chg) begin
          st_n = FW_FQ;
        end else begin
          pop  = 1'b1;
          st_n = FW_IDLE;
        end
      end
      FW_FQ: begin
        if (fq_ready) begin
          pop  = 1'b1;
          st_n = FW_IDLE;
        end
      end
      default: st_n = FW_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st <= FW_IDLE;
    else        st <= st_n;
  end

  assign lq_valid = (st == FW_LQ);
  assign fq_valid = (st == FW_FQ);
  assign lq_addr  = head_addr;
  assign fq_addr  = head_addr;

endmodule

// File: rtl/bus_sched_top.sv
module bus_sched_top
  import bus_sched_pkg::*;
#(
  parameter int AW       = 32,
  parameter int MAX_RD   = 6,
  parameter int CQ_DEPTH = 10,
  parameter int TQ_DEPTH = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sd_valid,
  output logic          sd_ready,
  input  logic [AW-1:0] sd_addr,
  input  logic          rd_valid,
  output logic          rd_ready,
  input  logic [AW-1:0] rd_addr,
  input  logic          rd_full,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [AW-1:0] wr_addr,
  input  logic          wr_full,
  input  logic          mc_busy,
  input  logic          rd_ret,
  output logic          bus_req,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic [1:0]    tx_kind,
  output logic [AW-1:0] tx_addr,
  input  logic          sn_valid,
  input  logic          sn_is_tlb,
  input  logic [AW-1:0] sn_addr,
  output logic          lq_valid,
  input  logic          lq_ready,
  output logic [AW-1:0] lq_addr,
  input  logic          lq_chg,
  output logic          fq_valid,
  input  logic          fq_ready,
  output logic [AW-1:0] fq_addr,
  output logic          tq_valid,
  input  logic          tq_ready,
  output logic [AW-1:0] tq_addr
);

  localparam int RCW  = $clog2(MAX_RD+1);
  localparam int CQCW = $clog2(CQ_DEPTH+1);
  localparam int TQCW = $clog2(TQ_DEPTH+1);

  logic            rd_allow;
  logic [RCW-1:0]  rd_cnt;
  txk_e            kind_e;
  logic            cq_valid;
  logic [AW-1:0]   cq_head;
  logic            cq_pop;
  logic [CQCW-1:0] cq_cnt;
  logic [TQCW-1:0] tq_cnt;

  bus_sched_rdcred #(.MAX(MAX_RD)) u_cred (
    .clk    (clk),
    .rst_n  (rst_n),
    .issue  (rd_valid && rd_ready),
    .retire (rd_ret),
    .allow  (rd_allow),
    .count  (rd_cnt)
  );

  bus_sched_arb #(.AW(AW)) u_arb (
    .clk      (clk),
    .rst_n    (rst_n),
    .sd_valid (sd_valid),
    .sd_addr  (sd_addr),
    .rd_valid (rd_valid),
    .rd_addr  (rd_addr),
    .rd_allow (rd_allow),
    .wr_valid (wr_valid),
    .wr_addr  (wr_addr),
    .rd_full  (rd_full),
    .wr_full  (wr_full),
    .mc_busy  (mc_busy),
    .tx_ready (tx_ready),
    .sd_ready (sd_ready),
    .rd_ready (rd_ready),
    .wr_ready (wr_ready),
    .tx_valid (tx_valid),
    .tx_kind  (kind_e),
    .tx_addr  (tx_addr),
    .bus_req  (bus_req)
  );

  assign tx_kind = kind_e;

  bus_sched_fifo #(.DEPTH(CQ_DEPTH), .W(AW)) u_cq (
    .clk        (clk),
    .rst_n      (rst_n),
    .push       (sn_valid && !sn_is_tlb),
    .din        (sn_addr),
    .pop        (cq_pop),
    .head_valid (cq_valid),
    .head       (cq_head),
    .count      (cq_cnt)
  );

  bus_sched_fifo #(.DEPTH(TQ_DEPTH), .W(AW)) u_tq (
    .clk        (clk),
    .rst_n      (rst_n),
    .push       (sn_valid && sn_is_tlb),
    .din        (sn_addr),
    .pop        (tq_valid && tq_ready),
    .head_valid (tq_valid),
    .head       (tq_addr),
    .count      (tq_cnt)
  );

  bus_sched_fwd #(.AW(AW)) u_fwd (
    .clk        (clk),
    .rst_n      (rst_n),
    .head_valid (cq_valid),
    .head_addr  (cq_head),
    .pop        (cq_pop),
    .lq_valid   (lq_valid),
    .lq_ready   (lq_ready),
    .lq_addr    (lq_addr),
    .lq_chg     (lq_chg),
    .fq_valid   (fq_valid),
    .fq_ready   (fq_ready),
    .fq_addr    (fq_addr)
  );

endmodule

// File: rtl/bus_sched_chk.sv
module bus_sched_chk #(
  parameter int AW       = 32,
  parameter int MAX_RD   = 6,
  parameter int CQ_DEPTH = 10,
  parameter int TQ_DEPTH = 3
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          sd_valid,
  input logic                          sd_ready,
  input logic                          rd_valid,
  input logic                          rd_ready,
  input logic                          rd_full,
  input logic                          wr_valid,
  input logic                          wr_ready,
  input logic                          wr_full,
  input logic                          mc_busy,
  input logic                          tx_valid,
  input logic                          tx_ready,
  input logic [1:0]                    tx_kind,
  input logic [AW-1:0]                 tx_addr,
  input logic                          lq_valid,
  input logic                          lq_ready,
  input logic [AW-1:0]                 lq_addr,
  input logic                          lq_chg,
  input logic                          fq_valid,
  input logic                          sn_valid,
  input logic                          sn_is_tlb,
  input logic [$clog2(MAX_RD+1)-1:0]   rd_cnt,
  input logic [$clog2(CQ_DEPTH+1)-1:0] cq_cnt,
  input logic [$clog2(TQ_DEPTH+1)-1:0] tq_cnt
);

  logic slot_free;
  assign slot_free = !tx_valid || tx_ready;

  p_prio_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sd_valid && slot_free |-> sd_ready && !rd_ready && !wr_ready);

  p_wfirst_r3: assert property (@(posedge clk) disable iff (!rst_n)
    slot_free && !sd_valid && wr_valid && mc_busy && rd_full && wr_full |-> wr_ready && !rd_ready);

  p_bypass_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && rd_ready |=> tx_valid && tx_kind == 2'd2);

  p_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_kind) && $stable(tx_addr));

  p_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ready |-> rd_cnt < ($clog2(MAX_RD+1))'(MAX_RD));

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sn_valid && !sn_is_tlb |-> cq_cnt < ($clog2(CQ_DEPTH+1))'(CQ_DEPTH));

  p_tlb_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sn_valid && sn_is_tlb |-> tq_cnt < ($clog2(TQ_DEPTH+1))'(TQ_DEPTH));

  p_full_after_chg_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fq_valid) |-> $past(lq_chg) && !lq_valid);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    lq_valid && !lq_ready |=> lq_valid && $stable(lq_addr));

endmodule

bind bus_sched_top bus_sched_chk #(
  .AW(AW), .MAX_RD(MAX_RD), .CQ_DEPTH(CQ_DEPTH), .TQ_DEPTH(TQ_DEPTH)
) chk_i (
  .clk(clk), .rst_n(rst_n),
  .sd_valid(sd_valid), .sd_ready(sd_ready),
  .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_full(rd_full),
  .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_full(wr_full),
  .mc_busy(mc_busy),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_kind(tx_kind), .tx_addr(tx_addr),
  .lq_valid(lq_valid), .lq_ready(lq_ready), .lq_addr(lq_addr), .lq_chg(lq_chg),
  .fq_valid(fq_valid),
  .sn_valid(sn_valid), .sn_is_tlb(sn_is_tlb),
  .rd_cnt(rd_cnt), .cq_cnt(cq_cnt), .tq_cnt(tq_cnt)
);

// File: tb/bus_sched_top_tb_top.sv
`timescale 1ns/1ps
module bus_sched_top_tb_top;

  localparam int AW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic sd_valid = 0, rd_valid = 0, wr_valid = 0;
  logic sd_ready, rd_ready, wr_ready;
  logic [AW-1:0] sd_addr = '0, rd_addr = '0, wr_addr = '0;
  logic rd_full = 0, wr_full = 0, mc_busy = 0, rd_ret = 0;
  logic bus_req, tx_valid;
  logic tx_ready = 1;
  logic [1:0] tx_kind;
  logic [AW-1:0] tx_addr;
  logic sn_valid = 0, sn_is_tlb = 0;
  logic [AW-1:0] sn_addr = '0;
  logic lq_valid, fq_valid, tq_valid;
  logic lq_ready = 0, fq_ready = 1, tq_ready = 0;
  logic lq_chg = 0;
  logic [AW-1:0] lq_addr, fq_addr, tq_addr;

  bus_sched_top dut_i (
    .clk(clk), .rst_n(rst_n),
    .sd_valid(sd_valid), .sd_ready(sd_ready), .sd_addr(sd_addr),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr), .rd_full(rd_full),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_full(wr_full),
    .mc_busy(mc_busy), .rd_ret(rd_ret), .bus_req(bus_req),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_kind(tx_kind), .tx_addr(tx_addr),
    .sn_valid(sn_valid), .sn_is_tlb(sn_is_tlb), .sn_addr(sn_addr),
    .lq_valid(lq_valid), .lq_ready(lq_ready), .lq_addr(lq_addr), .lq_chg(lq_chg),
    .fq_valid(fq_valid), .fq_ready(fq_ready), .fq_addr(fq_addr),
    .tq_valid(tq_valid), .tq_ready(tq_ready), .tq_addr(tq_addr)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Core-side logs, sampled mid low phase
  logic [AW-1:0] lq_log [64];
  logic [AW-1:0] fq_log [64];
  logic [AW-1:0] tq_log [16];
  logic [AW-1:0] exp_lq [64];
  logic [AW-1:0] exp_fq [64];
  logic [AW-1:0] exp_tq [16];
  int lq_n = 0, fq_n = 0, tq_n = 0;
  int elq_n = 0, efq_n = 0, etq_n = 0;

  always @(negedge clk) begin
    #2;
    if (lq_valid && lq_ready) begin
      lq_log[lq_n] = lq_addr;
      lq_n++;
      lq_chg = lq_addr[0];
    end
    if (fq_valid && fq_ready) begin
      fq_log[fq_n] = fq_addr;
      fq_n++;
    end
    if (tq_valid && tq_ready) begin
      tq_log[tq_n] = tq_addr;
      tq_n++;
    end
  end

  // vector: [7:6] expected kind, [5] sd, [4] rd, [3] wr, [2] rd_full, [1] wr_full, [0] mc_busy
  localparam logic [7:0] VEC [9] = '{
    8'b01_111_111,
    8'b10_011_000,
    8'b11_011_111,
    8'b10_011_110,
    8'b10_011_101,
    8'b11_001_000,
    8'b10_010_111,
    8'b01_101_000,
    8'b00_000_000
  };

  task automatic push_snoop(input logic tlb, input logic [AW-1:0] a);
    sn_valid  = 1;
    sn_is_tlb = tlb;
    sn_addr   = a;
    if (tlb) begin exp_tq[etq_n] = a; etq_n++; end
    else begin
      exp_lq[elq_n] = a; elq_n++;
      if (a[0]) begin exp_fq[efq_n] = a; efq_n++; end
    end
    @(negedge clk);
    sn_valid = 0;
  endtask

  task automatic compare_logs();
    chk(lq_n == elq_n, "R7 light query count", lq_n, elq_n);
    for (int i = 0; i < elq_n; i++)
      chk(lq_log[i] == exp_lq[i], "R9 light query order", lq_log[i], exp_lq[i]);
    chk(fq_n == efq_n, "R8 full query count", fq_n, efq_n);
    for (int i = 0; i < efq_n; i++)
      chk(fq_log[i] == exp_fq[i], "R8 full query address", fq_log[i], exp_fq[i]);
    chk(tq_n == etq_n, "R10 tlb snoop count", tq_n, etq_n);
    for (int i = 0; i < etq_n; i++)
      chk(tq_log[i] == exp_tq[i], "R10 tlb snoop order", tq_log[i], exp_tq[i]);
  endtask

  initial begin
    #1200000;
    n_fail++;
    n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int nrd;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(!tx_valid, "R1 tx_valid", tx_valid, 0);
    chk(!bus_req, "R1 bus_req", bus_req, 0);
    chk(!lq_valid && !fq_valid, "R1 queries", {lq_valid, fq_valid}, 0);
    chk(!tq_valid, "R1 tq_valid", tq_valid, 0);
    chk(!sd_ready && !rd_ready && !wr_ready, "R1 readies", {sd_ready, rd_ready, wr_ready}, 0);

    // Priority table walk: R2, R3, R4
    for (int i = 0; i < 9; i++) begin
      logic [1:0] ek;
      logic [AW-1:0] ea;
      ek = VEC[i][7:6];
      sd_valid = VEC[i][5]; rd_valid = VEC[i][4]; wr_valid = VEC[i][3];
      rd_full  = VEC[i][2]; wr_full  = VEC[i][1]; mc_busy  = VEC[i][0];
      sd_addr = 32'hA000_0000 + i; rd_addr = 32'hB000_0000 + i; wr_addr = 32'hC000_0000 + i;
      ea = (ek == 2'd1) ? sd_addr : (ek == 2'd2) ? rd_addr : (ek == 2'd3) ? wr_addr : '0;
      #1;
      chk(bus_req == (VEC[i][5] | VEC[i][4] | VEC[i][3]), "R4 bus_req same cycle", bus_req, VEC[i][5] | VEC[i][4] | VEC[i][3]);
      chk(!tx_valid, "R4 not before edge", tx_valid, 0);
      @(negedge clk);
      sd_valid = 0; rd_valid = 0; wr_valid = 0;
      chk(tx_kind == ek, (ek == 2'd3 && VEC[i][0]) ? "R3 write first kind" : "R2 kind", tx_kind, ek);
      chk(tx_valid == (ek != 2'd0), "R4 tx_valid next cycle", tx_valid, ek != 2'd0);
      if (ek != 2'd0) chk(tx_addr == ea, "R4 tx_addr", tx_addr, ea);
      rd_ret = (ek == 2'd2);
      @(negedge clk);
      rd_ret = 0;
    end
    rd_full = 0; wr_full = 0; mc_busy = 0;

    // R5 stall holds transaction
    tx_ready = 0;
    wr_valid = 1; wr_addr = 32'hC0DE_0001;
    @(negedge clk);
    wr_valid = 0; rd_valid = 1; rd_addr = 32'hBEEF_0002;
    for (int k = 0; k < 3; k++) begin
      #1;
      chk(tx_valid && tx_kind == 2'd3 && tx_addr == 32'hC0DE_0001, "R5 held write", tx_addr, 32'hC0DE_0001);
      chk(!rd_ready, "R5 no take while stalled", rd_ready, 0);
      @(negedge clk);
    end
    tx_ready = 1;
    #1;
    chk(rd_ready, "R5 take on release", rd_ready, 1);
    @(negedge clk);
    rd_valid = 0;
    chk(tx_kind == 2'd2 && tx_addr == 32'hBEEF_0002, "R5 next transaction", tx_addr, 32'hBEEF_0002);
    rd_ret = 1;
    @(negedge clk);
    rd_ret = 0;

    // R6 outstanding limit, return coinciding with blocked read
    nrd = 0;
    rd_valid = 1; rd_addr = 32'hB600_0000;
    for (int k = 0; k < 10; k++) begin
      #1;
      if (rd_ready) nrd++;
      @(negedge clk);
    end
    chk(nrd == 6, "R6 reads taken up to limit", nrd, 6);
    rd_ret = 1;
    #1;
    chk(!rd_ready, "R6 blocked in return cycle", rd_ready, 0);
    @(negedge clk);
    rd_ret = 0;
    #1;
    chk(rd_ready, "R6 taken after return", rd_ready, 1);
    @(negedge clk);
    #1;
    chk(!rd_ready, "R6 blocked again", rd_ready, 0);
    wr_valid = 1; wr_addr = 32'hC600_0000;
    #1;
    chk(wr_ready, "R6 write passes blocked read", wr_ready, 1);
    @(negedge clk);
    rd_valid = 0; wr_valid = 0;
    for (int k = 0; k < 6; k++) begin
      rd_ret = 1;
      @(negedge clk);
    end
    rd_ret = 0;
    rd_valid = 1;
    #1;
    chk(rd_ready, "R6 all retired", rd_ready, 1);
    @(negedge clk);
    rd_valid = 0;
    rd_ret = 1;
    @(negedge clk);
    rd_ret = 0;

    // R7 burst into both queues with core stalled
    lq_ready = 0; tq_ready = 0; fq_ready = 1;
    for (int k = 0; k < 10; k++) begin
      push_snoop(1'b0, 32'h0000_0100 + k);
      if (k < 3) push_snoop(1'b1, 32'h0000_7700 + 16 * k);
    end
    repeat (5) @(negedge clk);
    chk(lq_valid && lq_addr == 32'h100, "R9 head held while stalled", lq_addr, 32'h100);
    chk(tq_valid && tq_addr == 32'h7700, "R10 tlb head", tq_addr, 32'h7700);
    lq_ready = 1; tq_ready = 1;
    repeat (80) @(negedge clk);
    compare_logs();

    // Same-cycle push and retire: back-to-back snoops while draining
    for (int k = 0; k < 8; k++)
      push_snoop(1'b0, 32'h0000_0200 + 3 * k);
    push_snoop(1'b1, 32'h0000_8800);
    repeat (60) @(negedge clk);
    compare_logs();
    chk(!lq_valid && !fq_valid && !tq_valid, "R9 drained", {lq_valid, fq_valid, tq_valid}, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule